// File: doc/BRIEF.md
# Lucas Parameter Search Engine

This block prepares the inputs of a strong Lucas probable-prime test. Given an odd candidate N, it walks a fixed list of signed discriminants D whose magnitude starts at 5 and grows by 2 per trial, with the sign alternating (+5, -7, +9, -11, ...). For each D it evaluates the Jacobi symbol (D/N) and stops at the first D for which the symbol is -1. It then reports D together with the Lucas parameters P = 1 and Q = (1 - D)/4.

The Jacobi symbol is computed by an iterative engine that uses no divider. Each step does exactly one of these: halve an even numerator, subtract the modulus, or swap the two arguments. Sign corrections come from the low bits of the modulus.

The search can end in two other ways. If a trial gives a zero symbol for a D whose magnitude differs from N, then N shares a factor with D, and the block ends with a composite flag. If a caller-supplied number of trials runs out first, the block ends with a timeout flag. The timeout bounds the run for inputs such as perfect squares, for which no suitable D exists.

Top module: `lps_top`

## Requirements
- R1: After reset, done, composite and timeout are 0, and d_out, p_out and q_out are 0.
- R2: Trial k (counted from 0) uses |D| = 5 + 2k. D is positive for even k and negative for odd k. The reported D is the first one in this order whose Jacobi symbol is -1.
- R3: The Jacobi symbol (D/N) is the standard one for odd N: -1, 0 or +1, with negative D allowed.
- R4: On success, p_out = 1 and q_out = (1 - d_out)/4 as two's-complement values, and composite = timeout = 0.
- R5: If a trial gives symbol 0 and |D| differs from N, the block finishes with composite = 1 and d_out = that D. In this case p_out = 0, q_out = 0 and timeout = 0.
- R6: A trial with symbol 0 and |D| equal to N does not end the search; the next D is tried.
- R7: If max_trials trials complete without either ending, the block finishes with timeout = 1, d_out = p_out = q_out = 0 and composite = 0. With max_trials = 0 it times out without evaluating any D.
- R8: done is a single-cycle pulse. At done exactly one of success (p_out = 1), composite and timeout holds. All result outputs keep their values until the next accepted start.
- R9: A start pulse that arrives while a search is in progress is ignored. The running search completes on the N and max_trials captured at its own start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a search; accepted only when idle |
| n_in | input | NW | Odd candidate N, sampled on an accepted start |
| max_trials | input | TW | Maximum number of D values to try |
| done | output | 1 | One-cycle pulse marking a finished search |
| d_out | output | TW+3 | Signed discriminant D found (or the factor-revealing D) |
| p_out | output | TW+3 | Signed Lucas P: 1 on success, else 0 |
| q_out | output | TW+3 | Signed Lucas Q = (1 - D)/4 on success, else 0 |
| composite | output | 1 | N shown to share a factor with D |
| timeout | output | 1 | Trial limit reached without a result |

## Verification
The bound checker watches the following on every cycle:
- done never lasts more than one cycle, and it always carries exactly one outcome.
- A successful result satisfies 4Q = 1 - D.
- A composite verdict never names a D whose magnitude equals N.
- The Jacobi modulus stays odd throughout its reduction.
- No trial is launched beyond the captured limit.
- The captured N is not disturbed by a start that arrives mid-search.

Whether the reported D is the first one in the sequence with symbol -1 can only be shown by the bench's scenarios. The same holds for the value of each Jacobi symbol. The bench covers these by sweeping every odd N in a range against an arithmetic model that uses modulo reduction. It also runs directed cases for the equal-magnitude skip, the limit of zero, and a start that arrives while busy.

// File: rtl/lps_pkg.sv
package lps_pkg;

  typedef enum logic [1:0] {
    JAC_ZERO = 2'd0,
    JAC_POS  = 2'd1,
    JAC_NEG  = 2'd2
  } jac_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_TRY  = 2'd1,
    ST_WAIT = 2'd2
  } lps_state_t;

  // Halving the numerator flips the sign when the modulus is 3 or 5 mod 8.
  function automatic logic halve_flips(input logic [2:0] mod_low);
    return (mod_low == 3'd3) || (mod_low == 3'd5);
  endfunction

  // Exchanging the arguments flips the sign when both are 3 mod 4.
  function automatic logic swap_flips(input logic [1:0] num_low, input logic [1:0] mod_low);
    return (num_low == 2'b11) && (mod_low == 2'b11);
  endfunction

  // Sign contributed by a negative numerator: (-1)^((N-1)/2).
  function automatic logic neg_flips(input logic [1:0] mod_low);
    return mod_low == 2'b11;
  endfunction

endpackage

// File: rtl/lps_disc.sv
module lps_disc #(
  parameter int TW = 6,
  localparam int DW = TW + 2
) (
  input  logic [TW-1:0]        idx,
  output logic [DW-1:0]        mag,
  output logic                 neg,
  output logic signed [DW:0]   d_val,
  output logic signed [DW:0]   q_val
);

  logic signed [DW:0] one_minus_d;

  always_comb begin
    mag         = DW'(5) + DW'({idx, 1'b0});
    neg         = idx[0];
    d_val       = neg ? -$signed({1'b0, mag}) : $signed({1'b0, mag});
    one_minus_d = $signed((DW+1)'(1)) - d_val;
    q_val       = one_minus_d >>> 2;
  end

endmodule

// File: rtl/lps_jacobi.sv
module lps_jacobi
  import lps_pkg::*;
#(
  parameter int NW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic [NW-1:0] a_in,
  input  logic [NW-1:0] n_in,
  input  logic          neg_in,
  output logic          busy,
  output logic          fin,
  output jac_t          res,
  output logic          mod_lsb
);

  logic [NW-1:0] a_q;
  logic [NW-1:0] n_q;
  logic          t_q;
  logic          busy_q;
  logic          fin_q;
  jac_t          res_q;

  logic a_zero;
  logic a_even;
  logic a_ge_n;

  assign a_zero = (a_q == '0);
  assign a_even = ~a_q[0];
  assign a_ge_n = (a_q >= n_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a_q    <= '0;
      n_q    <= NW'(1);
      t_q    <= 1'b0;
      busy_q <= 1'b0;
      fin_q  <= 1'b0;
      res_q  <= JAC_ZERO;
    end else begin
      fin_q <= 1'b0;
      if (go && !busy_q) begin
        a_q    <= a_in;
        n_q    <= n_in;
        t_q    <= neg_in && neg_flips(n_in[1:0]);
        busy_q <= 1'b1;
      end else if (busy_q) begin
        if (a_zero) begin
          busy_q <= 1'b0;
          fin_q  <= 1'b1;
          if (n_q == NW'(1)) res_q <= t_q ? JAC_NEG : JAC_POS;
          else               res_q <= JAC_ZERO;
        end else if (a_even) begin
          a_q <= a_q >> 1;
          if (halve_flips(n_q[2:0])) t_q <= ~t_q;
        end else if (a_ge_n) begin
          a_q <= a_q - n_q;
        end else begin
          a_q <= n_q;
          n_q <= a_q;
          if (swap_flips(a_q[1:0], n_q[1:0])) t_q <= ~t_q;
        end
      end
    end
  end

  assign busy    = busy_q;
  assign fin     = fin_q;
  assign res     = res_q;
  assign mod_lsb = n_q[0];

endmodule

// File: rtl/lps_top.sv
module lps_top
  import lps_pkg::*;
#(
  parameter int NW = 12,
  parameter int TW = 6,
  localparam int DW = TW + 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [NW-1:0]       n_in,
  input  logic [TW-1:0]       max_trials,
  output logic                done,
  output logic signed [DW:0]  d_out,
  output logic signed [DW:0]  p_out,
  output logic signed [DW:0]  q_out,
  output logic                composite,
  output logic                timeout
);

  lps_state_t          state;
  logic [NW-1:0]       n_lat;
  logic [TW-1:0]       max_lat;
  logic [TW-1:0]       trial_idx;
  logic                done_q;
  logic                comp_q;
  logic                tmo_q;
  logic signed [DW:0]  d_q;
  logic signed [DW:0]  p_q;
  logic signed [DW:0]  q_q;

  // Named events for the checker.
  logic                busy;
  logic                limit_hit;
  logic                trial_fire;
  logic                jac_busy;
  logic                jac_fin;
  logic                jac_mod_lsb;
  jac_t                jac_res;
  logic [DW-1:0]       d_mag;
  logic                d_neg;
  logic signed [DW:0]  d_val;
  logic signed [DW:0]  q_val;
  logic                mag_is_n;

  lps_disc #(.TW(TW)) u_disc (
    .idx   (trial_idx),
    .mag   (d_mag),
    .neg   (d_neg),
    .d_val (d_val),
    .q_val (q_val)
  );

  assign busy       = (state != ST_IDLE);
  assign limit_hit  = (trial_idx == max_lat);
  assign trial_fire = (state == ST_TRY) && !limit_hit;
  assign mag_is_n   = (NW'(d_mag) == n_lat);

  lps_jacobi #(.NW(NW)) u_jac (
    .clk     (clk),
    .rst_n   (rst_n),
    .go      (trial_fire),
    .a_in    (NW'(d_mag)),
    .n_in    (n_lat),
    .neg_in  (d_neg),
    .busy    (jac_busy),
    .fin     (jac_fin),
    .res     (jac_res),
    .mod_lsb (jac_mod_lsb)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      n_lat     <= '0;
      max_lat   <= '0;
      trial_idx <= '0;
      done_q    <= 1'b0;
      comp_q    <= 1'b0;
      tmo_q     <= 1'b0;
      d_q       <= '0;
      p_q       <= '0;
      q_q       <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            n_lat     <= n_in;
            max_lat   <= max_trials;
            trial_idx <= '0;
            comp_q    <= 1'b0;
            tmo_q     <= 1'b0;
            d_q       <= '0;
            p_q       <= '0;
            q_q       <= '0;
            state     <= ST_TRY;
          end
        end
        ST_TRY: begin
          if (limit_hit) begin
            tmo_q  <= 1'b1;
            done_q <= 1'b1;
            state  <= ST_IDLE;
          end else begin
            state <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (jac_fin) begin
            if (jac_res == JAC_NEG) begin
              d_q    <= d_val;
              q_q    <= q_val;
              p_q    <= (DW+1)'(1);
              done_q <= 1'b1;
              state  <= ST_IDLE;
            end else if (jac_res == JAC_ZERO && !mag_is_n) begin
              d_q    <= d_val;
              comp_q <= 1'b1;
              done_q <= 1'b1;
              state  <= ST_IDLE;
            end else begin
              trial_idx <= trial_idx + TW'(1);
              state     <= ST_TRY;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign done      = done_q;
  assign d_out     = d_q;
  assign p_out     = p_q;
  assign q_out     = q_q;
  assign composite = comp_q;
  assign timeout   = tmo_q;

endmodule

// File: rtl/lps_check.sv
module lps_check #(
  parameter int NW = 12,
  parameter int TW = 6,
  localparam int DW = TW + 2
) (
  input logic                clk,
  input logic                rst_n,
  input logic                start,
  input logic                done,
  input logic signed [DW:0]  d_out,
  input logic signed [DW:0]  p_out,
  input logic signed [DW:0]  q_out,
  input logic                composite,
  input logic                timeout,
  input logic                busy,
  input logic                trial_fire,
  input logic [TW-1:0]       trial_idx,
  input logic [TW-1:0]       max_lat,
  input logic [NW-1:0]       n_lat,
  input logic [DW-1:0]       d_mag,
  input logic                jac_busy,
  input logic                jac_mod_lsb
);

  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r8_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $countones({composite, timeout, (p_out == (DW+1)'(1))}) == 1);

  a_r4_q_relation: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !composite && !timeout) |-> (int'(q_out) * 4 == 1 - int'(d_out)));

  a_r5_not_self: assert property (@(posedge clk) disable iff (!rst_n)
    (done && composite) |-> (NW'(d_mag) != n_lat));

  a_r3_mod_odd: assert property (@(posedge clk) disable iff (!rst_n)
    jac_busy |-> jac_mod_lsb);

  a_r7_trial_bound: assert property (@(posedge clk) disable iff (!rst_n)
    trial_fire |-> (trial_idx < max_lat));

  a_r9_hold_n: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> $stable(n_lat));

endmodule

bind lps_top lps_check #(.NW(NW), .TW(TW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start       (start),
  .done        (done),
  .d_out       (d_out),
  .p_out       (p_out),
  .q_out       (q_out),
  .composite   (composite),
  .timeout     (timeout),
  .busy        (busy),
  .trial_fire  (trial_fire),
  .trial_idx   (trial_idx),
  .max_lat     (max_lat),
  .n_lat       (n_lat),
  .d_mag       (d_mag),
  .jac_busy    (jac_busy),
  .jac_mod_lsb (jac_mod_lsb)
);

// File: tb/lps_top_test.sv
module lps_top_test;

  localparam int NW = 12;
  localparam int TW = 6;
  localparam int DW = TW + 2;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG = 20000;

  logic                clk = 1'b0;
  logic                rst_n = 1'b0;
  logic                start = 1'b0;
  logic [NW-1:0]       n_in = '0;
  logic [TW-1:0]       max_trials = '0;
  logic                done;
  logic signed [DW:0]  d_out;
  logic signed [DW:0]  p_out;
  logic signed [DW:0]  q_out;
  logic                composite;
  logic                timeout;

  int checks = 0;
  int errors = 0;

  int exp_kind, exp_d, exp_q, exp_p;
  bit hung;

  always #(CLK_PERIOD/2) clk = ~clk;

  lps_top #(.NW(NW), .TW(TW)) uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .n_in       (n_in),
    .max_trials (max_trials),
    .done       (done),
    .d_out      (d_out),
    .p_out      (p_out),
    .q_out      (q_out),
    .composite  (composite),
    .timeout    (timeout)
  );

  task automatic chk(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s got %0d expected %0d", tag, got, exp);
    end
  endtask

  // Classical Jacobi symbol using modulo reduction.
  function automatic int ref_jacobi(input int a0, input int n0);
    int a, n, t, tmp;
    n = n0;
    a = a0 % n;
    if (a < 0) a += n;
    t = 1;
    while (a != 0) begin
      while (a % 2 == 0) begin
        a = a / 2;
        if (n % 8 == 3 || n % 8 == 5) t = -t;
      end
      tmp = a; a = n; n = tmp;
      if (a % 4 == 3 && n % 4 == 3) t = -t;
      a = a % n;
    end
    return (n == 1) ? t : 0;
  endfunction

  // kind: 0 success, 1 composite, 2 timeout
  task automatic ref_search(input int n, input int mx);
    exp_kind = 2; exp_d = 0; exp_q = 0; exp_p = 0;
    for (int k = 0; k < mx; k++) begin
      int mag, d, j;
      mag = 5 + 2 * k;
      d = (k % 2 == 1) ? -mag : mag;
      j = ref_jacobi(d, n);
      if (j == -1) begin
        exp_kind = 0; exp_d = d; exp_q = (1 - d) / 4; exp_p = 1;
        return;
      end
      if (j == 0 && mag != n) begin
        exp_kind = 1; exp_d = d;
        return;
      end
    end
  endtask

  task automatic wait_done();
    int cyc = 0;
    hung = 0;
    while (!done) begin
      @(negedge clk);
      cyc++;
      if (cyc > WATCHDOG) begin
        hung = 1;
        checks++;
        errors++;
        $display("FAIL watchdog got %0d expected done", cyc);
        return;
      end
    end
  endtask

  task automatic launch(input int n, input int mx);
    @(negedge clk);
    n_in = NW'(n);
    max_trials = TW'(mx);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  function automatic int kind_of();
    return composite ? 1 : (timeout ? 2 : 0);
  endfunction

  task automatic run_and_check(input int n, input int mx, input string tag);
    launch(n, mx);
    wait_done();
    if (hung) return;
    ref_search(n, mx);
    chk({tag, " kind"}, kind_of(), exp_kind);
    chk({tag, " D"}, int'(d_out), exp_d);
    chk({tag, " Q"}, int'(q_out), exp_q);
    chk({tag, " P"}, int'(p_out), exp_p);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 done", int'(done), 0);
    chk("R1 composite", int'(composite), 0);
    chk("R1 timeout", int'(timeout), 0);
    chk("R1 d_out", int'(d_out), 0);
    chk("R1 p_out", int'(p_out), 0);
    chk("R1 q_out", int'(q_out), 0);
    rst_n = 1'b1;

    // R4: N=5 -> D=-7 (D=5 skipped since |D|==N), Q=2
    run_and_check(5, 63, "R4 N=5");
    chk("R4 N=5 D direct", int'(d_out), -7);
    chk("R4 N=5 Q direct", int'(q_out), 2);

    // R8: done single cycle, results held afterwards
    @(negedge clk);
    chk("R8 done pulse", int'(done), 0);
    repeat (4) @(negedge clk);
    chk("R8 hold D", int'(d_out), -7);
    chk("R8 hold P", int'(p_out), 1);

    // R5: N=15 shares factor 5 with the first D
    run_and_check(15, 63, "R5 N=15");
    chk("R5 composite", int'(composite), 1);
    chk("R5 D", int'(d_out), 5);

    // R6: N=9 skips D=9 and is exposed by D=-15
    run_and_check(9, 63, "R6 N=9");
    chk("R6 D", int'(d_out), -15);

    // R7: N=1 never yields -1; limit of 0 yields immediate timeout
    run_and_check(1, 4, "R7 N=1");
    chk("R7 timeout", int'(timeout), 1);
    run_and_check(7, 0, "R7 zero limit");
    chk("R7 zero-limit timeout", int'(timeout), 1);
    // N=9 with limit 2: D=5,-7 give +1 -> timeout
    run_and_check(9, 2, "R7 N=9 short");

    // R9: second start while busy is ignored
    launch(15, 63);
    n_in = NW'(7);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done();
    if (!hung) begin
      chk("R9 composite", int'(composite), 1);
      chk("R9 D", int'(d_out), 5);
    end

    // R2 R3: sweep every odd N in range against the model
    for (int n = 3; n < 1024; n += 2) begin
      run_and_check(n, 63, "R2 R3 sweep");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule